// File: doc/BRIEF.md
# Interrupt Enable and Flag Controller

This block gathers the six interrupt request sources of a small 8-bit microcontroller: two external request lines, overflow events from three timers, and one serial event. It latches each request into a flag. It masks the flags with a per-source enable and a global enable. It then presents a registered pending vector, a single request line and the index of the request that wins under a fixed polling order.

The CPU acknowledges the presented index with a one-cycle pulse. Hardware then clears the flags that it is allowed to clear. A small register port lets software read and write the enables and the flags.

Timer 2 has two flags: overflow and capture/reload. They are combined into one request. Timer 2 is sampled in the same cycle as its event, while the timer 0 and timer 1 flags are sampled one cycle after theirs. A timer 2 request therefore reaches the CPU one cycle earlier.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the enables, all flags, `pend`, `irq`, `irq_id` and `rdata` are 0.
- R2: Register 0 holds the enables: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 7 global. Bits 6 and 5 read back as 0, and writes to them are ignored.
- R3: While the global enable is 0, `pend` is all zero and `irq` is 0, whatever the per-source bits hold.
- R4: External line k sets its flag when it is high in a cycle after being low in the previous cycle. Holding the line high does not set the flag again once it has been cleared. The pending bit appears 2 cycles after the first high cycle.
- R5: A timer 0 or timer 1 pulse in cycle N sets the flag at the end of N. The enabled pending bit is visible in cycle N+2 and not in N+1.
- R6: Register 1 holds timer 2: bit 0 overflow flag, bit 1 capture flag, bit 2 timer 2 enable. The timer 2 request is the OR of the two flags. An overflow or capture pulse in cycle N makes `pend[5]` visible in cycle N+1.
- R7: `ack` while `irq` is 1 clears the flag of the source in `irq_id` when that source is external 0, timer 0, external 1 or timer 1. Its pending bit drops in the next cycle. The serial flag and both timer 2 flags survive `ack`, and only a register write clears them.
- R8: `pend` bit indices are external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4, timer 2 = 5. `irq_id` is the lowest set index of `pend`, and 0 when nothing is pending.
- R9: A hardware event in the same cycle as an `ack` or a software write that would clear that flag leaves the flag set.
- R10: `rdata` shows, one cycle after `addr`, register 0, register 1, or register 2 (flags of indices 0..4 at bits 0..4); address 3 reads 0. A write to register 2 loads those five flags.
- R11: `pend[i]` is set exactly when flag i, its enable and the global enable are set, and `irq` is the OR of `pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 2 | External request lines, rising-edge detected |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| t2_ovf | input | 1 | Timer 2 overflow pulse |
| t2_cap | input | 1 | Timer 2 capture/reload pulse |
| ser_evt | input | 1 | Serial event pulse |
| ack | input | 1 | Vector acknowledge for the presented `irq_id` |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Registered read data |
| pend | output | 6 | Enabled pending requests |
| irq | output | 1 | Interrupt request to the CPU |
| irq_id | output | 3 | Index of the winning pending request |

## Verification
Two functions can fall in the same cycle and fight over a flag:
- **Acknowledge against a new event.** The bench drives `ack` for the presented timer 0 request together with a fresh timer 0 pulse. `pend[1]` must drop for exactly one cycle and return in the next, and register 2 must still show the flag.
- **Software clear against a new event.** A write that clears the timer 2 flags coincides with a timer 2 overflow pulse. `pend[5]` must stay set, and register 1 must read back with the overflow flag still 1.

Around these cases, sweeps cover:
- all 256 enable values with each source fired alone;
- all 63 source combinations, each drained by repeated acknowledges.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_SRC  = 6;
  localparam int NUM_FLAG = 5;
  localparam int NUM_EXT  = 2;
  localparam int ID_W     = $clog2(NUM_SRC);

  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;
  localparam int SRC_TMR2 = 5;

  // flags that a vector acknowledge may clear
  localparam logic [NUM_FLAG-1:0] HW_ACK_CLEAR = 5'b01111;

  localparam int        GLOBAL_BIT = 7;
  localparam logic [7:0] EN_WMASK  = 8'h9F;

  localparam int T2_OVF_BIT = 0;
  localparam int T2_CAP_BIT = 1;
  localparam int T2_EN_BIT  = 2;

  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_T2   = 2'd1,
    REG_FLAG = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_rise
    assign rise[gi] = lvl[gi] & ~prev_q[gi];
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NF = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] hw_set,
  input  logic [NF-1:0] ack_clr,
  input  logic          wr_flag,
  input  logic          wr_t2,
  input  logic [DW-1:0] wdata,
  input  logic          t2_ovf,
  input  logic          t2_cap,
  output logic [NF-1:0] flag_q,
  output logic          tf2_q,
  output logic          exf2_q,
  output logic          t2_req_nxt
);
  import irq_ctrl_pkg::*;

  logic [NF-1:0] flag_d;
  logic          tf2_d, exf2_d;

  for (genvar gi = 0; gi < NF; gi++) begin : g_flag
    // a hardware set outranks both the software write and the acknowledge
    assign flag_d[gi] = hw_set[gi] |
                        (wr_flag ? wdata[gi] : (flag_q[gi] & ~ack_clr[gi]));

    always_ff @(posedge clk) begin
      if (rst) flag_q[gi] <= 1'b0;
      else     flag_q[gi] <= flag_d[gi];
    end
  end

  assign tf2_d  = t2_ovf | (wr_t2 ? wdata[T2_OVF_BIT] : tf2_q);
  assign exf2_d = t2_cap | (wr_t2 ? wdata[T2_CAP_BIT] : exf2_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tf2_q  <= 1'b0;
      exf2_q <= 1'b0;
    end else begin
      tf2_q  <= tf2_d;
      exf2_q <= exf2_d;
    end
  end

  assign t2_req_nxt = tf2_d | exf2_d;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] id,
  output logic          any
);
  always_comb begin
    id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) id = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [irq_ctrl_pkg::NUM_EXT-1:0] ext_in,
  input  logic                           t0_ovf,
  input  logic                           t1_ovf,
  input  logic                           t2_ovf,
  input  logic                           t2_cap,
  input  logic                           ser_evt,
  input  logic                           ack,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [irq_ctrl_pkg::NUM_SRC-1:0] pend,
  output logic                           irq,
  output logic [irq_ctrl_pkg::ID_W-1:0]  irq_id
);
  import irq_ctrl_pkg::*;

  logic [DATA_W-1:0]   en_q;
  logic                t2en_q;
  logic [NUM_EXT-1:0]  ext_rise;
  logic [NUM_FLAG-1:0] hw_set, ack_clr, flag_q;
  logic                tf2_q, exf2_q, t2_req_nxt;
  logic                wr_enreg, wr_t2, wr_flag;
  logic [NUM_SRC-1:0]  pend_d;
  logic [ID_W-1:0]     id_d;
  logic                any_d;
  logic                glob;
  logic [DATA_W-1:0]   rd_mux;

  assign wr_enreg = wr_en && (addr == ADDR_W'(REG_EN));
  assign wr_t2    = wr_en && (addr == ADDR_W'(REG_T2));
  assign wr_flag  = wr_en && (addr == ADDR_W'(REG_FLAG));
  assign glob     = en_q[GLOBAL_BIT];

  irq_edge_det #(.W(NUM_EXT)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (ext_in),
    .rise(ext_rise)
  );

  assign hw_set[SRC_EXT0] = ext_rise[0];
  assign hw_set[SRC_TMR0] = t0_ovf;
  assign hw_set[SRC_EXT1] = ext_rise[1];
  assign hw_set[SRC_TMR1] = t1_ovf;
  assign hw_set[SRC_SER]  = ser_evt;

  for (genvar gi = 0; gi < NUM_FLAG; gi++) begin : g_ack
    if (HW_ACK_CLEAR[gi]) begin : g_clr
      assign ack_clr[gi] = ack && irq && (irq_id == ID_W'(gi));
    end else begin : g_keep
      assign ack_clr[gi] = 1'b0;
    end
  end

  irq_flag_bank #(.NF(NUM_FLAG), .DW(DATA_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .hw_set    (hw_set),
    .ack_clr   (ack_clr),
    .wr_flag   (wr_flag),
    .wr_t2     (wr_t2),
    .wdata     (wdata),
    .t2_ovf    (t2_ovf),
    .t2_cap    (t2_cap),
    .flag_q    (flag_q),
    .tf2_q     (tf2_q),
    .exf2_q    (exf2_q),
    .t2_req_nxt(t2_req_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      t2en_q <= 1'b0;
    end else begin
      if (wr_enreg) en_q   <= wdata & DATA_W'(EN_WMASK);
      if (wr_t2)    t2en_q <= wdata[T2_EN_BIT];
    end
  end

  // timer 0/1, serial, external: registered flags -> one extra cycle
  for (genvar gi = 0; gi < NUM_FLAG; gi++) begin : g_pend
    assign pend_d[gi] = flag_q[gi] & ~ack_clr[gi] & en_q[gi] & glob;
  end
  // timer 2: sampled from the flag's next value in the event cycle
  assign pend_d[SRC_TMR2] = t2_req_nxt & t2en_q & glob;

  irq_prio_enc #(.N(NUM_SRC), .IW(ID_W)) u_prio (
    .req(pend_d),
    .id (id_d),
    .any(any_d)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(REG_EN): rd_mux = en_q;
      ADDR_W'(REG_T2): begin
        rd_mux[T2_OVF_BIT] = tf2_q;
        rd_mux[T2_CAP_BIT] = exf2_q;
        rd_mux[T2_EN_BIT]  = t2en_q;
      end
      ADDR_W'(REG_FLAG): rd_mux[NUM_FLAG-1:0] = flag_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      irq    <= 1'b0;
      irq_id <= '0;
      rdata  <= '0;
    end else begin
      pend   <= pend_d;
      irq    <= any_d;
      irq_id <= id_d;
      rdata  <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       t0_ovf,
  input logic       t2_ovf,
  input logic       t2_cap,
  input logic       ack,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] rdata,
  input logic [5:0] pend,
  input logic       irq,
  input logic [2:0] irq_id,
  input logic [7:0] en_q,
  input logic       t2en_q,
  input logic [4:0] flag_q,
  input logic       tf2_q
);
  p_irq_or_r11: assert property (@(posedge clk) disable iff (rst)
    irq == (|pend));

  p_global_off_r3: assert property (@(posedge clk) disable iff (rst)
    !en_q[7] |=> (pend == 6'd0));

  p_t2_same_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    ((t2_ovf || t2_cap) && t2en_q && en_q[7]) |=> pend[5]);

  p_t0_flag_next_r5: assert property (@(posedge clk) disable iff (rst)
    t0_ovf |=> flag_q[1]);

  p_t2_survives_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (tf2_q && !(wr_en && addr == 2'd1)) |=> tf2_q);

  p_ack_clears_t0_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && irq && irq_id == 3'd1 && !t0_ovf && !(wr_en && addr == 2'd2))
      |=> !flag_q[1]);

  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend[irq_id] && ((pend & ((6'd1 << irq_id) - 6'd1)) == 6'd0)));

  p_resv_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == 2'd0) |-> (rdata[6:5] == 2'b00));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .t0_ovf(t0_ovf),
  .t2_ovf(t2_ovf),
  .t2_cap(t2_cap),
  .ack   (ack),
  .wr_en (wr_en),
  .addr  (addr),
  .rdata (rdata),
  .pend  (pend),
  .irq   (irq),
  .irq_id(irq_id),
  .en_q  (en_q),
  .t2en_q(t2en_q),
  .flag_q(flag_q),
  .tf2_q (tf2_q)
);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_in = '0;
  logic       t0_ovf = 0, t1_ovf = 0, t2_ovf = 0, t2_cap = 0, ser_evt = 0;
  logic       ack = 0, wr_en = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] pend;
  logic       irq;
  logic [2:0] irq_id;

  int n_vec = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  irq_flag_ctrl uut (
    .clk(clk), .rst(rst), .ext_in(ext_in), .t0_ovf(t0_ovf), .t1_ovf(t1_ovf),
    .t2_ovf(t2_ovf), .t2_cap(t2_cap), .ser_evt(ser_evt), .ack(ack),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .pend(pend),
    .irq(irq), .irq_id(irq_id)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    tick();
    d = rdata;
  endtask

  task automatic drop_all();
    ext_in = '0; t0_ovf = 0; t1_ovf = 0; t2_ovf = 0; t2_cap = 0; ser_evt = 0;
  endtask

  // index order: ext0, t0, ext1, t1, serial, t2
  task automatic fire_mask(input logic [5:0] m, input bit use_cap);
    ext_in[0] = m[0]; t0_ovf = m[1]; ext_in[1] = m[2];
    t1_ovf = m[3]; ser_evt = m[4];
    if (use_cap) t2_cap = m[5]; else t2_ovf = m[5];
    tick();
    drop_all();
  endtask

  function automatic int lowest(input logic [5:0] v);
    for (int i = 5; i >= 0; i--) if (v[i]) lowest = i;
    if (v == 0) lowest = 0;
  endfunction

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [5:0] cur;
    logic [5:0] expb;
    int id;
    bit en_s;
    repeat (3) tick();
    chk("R1 pend", pend, 0);
    chk("R1 irq", irq, 0);
    chk("R1 irq_id", irq_id, 0);
    chk("R1 rdata", rdata, 0);
    rst = 1'b0;
    tick();
    bus_rd(2'd0, rd); chk("R1 enable reg", rd, 0);
    bus_rd(2'd1, rd); chk("R1 t2 reg", rd, 0);
    bus_rd(2'd2, rd); chk("R1 flag reg", rd, 0);

    // sweep: every enable value with each source alone (R2 R3 R4 R5 R6 R11)
    for (int e = 0; e < 256; e++) begin
      bus_wr(2'd0, 8'(e));
      bus_wr(2'd1, {5'b0, e[5], 2'b00});
      bus_rd(2'd0, rd); chk("R2 enable readback", rd, e & 8'h9F);
      for (int s = 0; s < 6; s++) begin
        en_s = (s < 5) ? e[s] : e[5];
        expb = (en_s && e[7]) ? 6'(1 << s) : 6'd0;
        fire_mask(6'(1 << s), e[0]);
        chk((s == 5) ? "R6 t2 early" : "R5 R4 not yet", pend, (s == 5) ? expb : 0);
        tick();
        chk("R11 R3 pend", pend, expb);
        chk("R11 irq", irq, (expb != 0) ? 1 : 0);
        chk("R8 irq_id", irq_id, (expb != 0) ? s : 0);
        if (s == 5) begin
          bus_rd(2'd1, rd);
          chk("R6 t2 flags", rd, {5'b0, e[5], e[0], ~e[0]});
        end else begin
          bus_rd(2'd2, rd);
          chk("R10 flag reg", rd, 1 << s);
        end
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd1, {5'b0, e[5], 2'b00});
        tick(); tick();
      end
    end

    // combinations drained by acknowledges (R7 R8)
    bus_wr(2'd0, 8'hFF);
    bus_wr(2'd1, 8'h04);
    for (int c = 1; c < 64; c++) begin
      fire_mask(6'(c), 1'b0);
      tick();
      cur = 6'(c);
      chk("R8 combo pend", pend, cur);
      for (int k = 0; k < 6; k++) begin
        id = lowest(cur);
        chk("R8 winner", irq_id, id);
        ack = 1'b1; tick(); ack = 1'b0;
        if (id < 4) cur[id] = 1'b0;
        chk("R7 after ack", pend, cur);
        if (id >= 4) break;
      end
      bus_rd(2'd3, rd); chk("R10 addr3 zero", rd, 0);
      bus_wr(2'd2, 8'h00);
      bus_wr(2'd1, 8'h04);
      tick(); tick();
      chk("R7 cleared by write", pend, 0);
    end

    // R4: held level does not re-set after ack
    ext_in[1] = 1'b1;
    tick(); tick();
    chk("R4 ext1 pending", pend, 6'b000100);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R4 ack clears", pend, 0);
    repeat (3) tick();
    chk("R4 held high no reset", pend, 0);
    bus_rd(2'd2, rd); chk("R4 flag stays clear", rd, 0);
    ext_in = '0;
    tick();

    // R9: ack and new timer 0 event in same cycle
    fire_mask(6'b000010, 1'b0);
    tick();
    chk("R9 t0 presented", irq_id, 1);
    ack = 1'b1; t0_ovf = 1'b1; tick(); ack = 1'b0; t0_ovf = 1'b0;
    chk("R9 one-cycle gap", pend, 0);
    tick();
    chk("R9 request returns", pend, 6'b000010);
    bus_rd(2'd2, rd); chk("R9 flag kept", rd, 8'h02);
    bus_wr(2'd2, 8'h00);

    // R9: software clear of t2 flags against a new overflow
    fire_mask(6'b100000, 1'b0);
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h04; t2_ovf = 1'b1;
    tick();
    wr_en = 1'b0; t2_ovf = 1'b0;
    chk("R9 t2 still pending", pend, 6'b100000);
    bus_rd(2'd1, rd); chk("R9 t2 flag kept", rd, 8'h05);

    // R7: ack leaves timer 2 alone
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R7 t2 survives ack", pend, 6'b100000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule